// File: doc/BRIEF.md
# Prioritized Interrupt Selector with Class Masking

This block decides which interrupt a processor core takes next and whether delivery is allowed. Requests come from three places. Two firmware-bound request lines carry initialization and performance-monitor requests. The third source is a bitmap of external vectors, which covers the non-maskable vector 2, the legacy-controller vector 0 and the numbered vectors 16 through 255. A pulse on a bit of that bitmap latches the vector as pending. The block also keeps an in-service bitmap, which records the external interrupts that have been accepted and not yet retired.

Every cycle the block works out the highest-ranked pending external vector. The top of the ranking is vector 2, then vector 0, then vectors 255 down to 16. The block masks that vector against three things: the in-service set, a mask-all bit, and a 4-bit class threshold that is compared with vector bits [7:4]. Status enables then gate delivery, and a legacy mode changes the external enable condition. The firmware requests take precedence over any external vector. An acknowledge moves the delivered external vector from pending to in-service. An end-of-interrupt retires the highest-ranked in-service vector. A separate output always shows the highest pending vector that passes masking, or 15 when no vector passes.

Top module: `intr_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, deliver_o is 0. Reset empties both the pending and the in-service bitmaps, so after reset hp_vec_o reads 15.
- R2: A 1 on raise_i[v] for one cycle makes vector v pending for v = 0, v = 2 and v = 16..255. A raise on vectors 1 and 3..15 is ignored.
- R3: External ranking from highest to lowest is vector 2, then vector 0, then vectors 255 down to 16. A higher number always wins, including two vectors in the same class.
- R4: When init_req_i = 1 and mchk_i = 0, the block delivers with fw_o = 1 and fw_init_o = 1, ahead of every other source. When mchk_i = 1 the init request is not delivered.
- R5: When pmi_req_i = 1 and coll_en_i = 1, the block delivers with fw_o = 1 and fw_init_o = 0. This source ranks below a qualifying init request and above every external vector. When coll_en_i = 0 the request is not delivered.
- R6: An external vector is delivered only when ien_i = 1. When legacy_i = 1 the enable is ien_i AND (NOT leg_cif_i OR leg_eif_i).
- R7: mask_all_i = 1 masks vector 0 and vectors 16..255 but not vector 2. A vector in 16..255 is masked unless its bits [7:4] are strictly greater than class_thr_i.
- R8: An external vector is masked unless it outranks every in-service vector under the ranking of R3.
- R9: hp_vec_o shows the highest-ranked pending external vector when that vector is unmasked. It shows 15 when nothing is pending or that vector is masked. The value does not depend on ien_i or legacy_i.
- R10: An ack_i while an external vector is being delivered clears that vector's pending bit and sets its in-service bit in the same clock. A masked or disabled request stays pending.
- R11: eoi_i clears only the highest-ranked in-service bit.
- R12: An ack_i while a firmware request is being delivered leaves both bitmaps unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | NUM_VEC | One-cycle pulses that make external vectors pending |
| init_req_i | input | 1 | Initialization request (firmware) |
| pmi_req_i | input | 1 | Performance-monitor request (firmware) |
| mask_all_i | input | 1 | Masks vector 0 and vectors 16..255 |
| class_thr_i | input | CLASS_W | Class threshold compared with vector bits [7:4] |
| mchk_i | input | 1 | Machine-check status; blocks the init request when 1 |
| coll_en_i | input | 1 | Interruption-collection status; enables the performance-monitor request |
| ien_i | input | 1 | External interrupt enable |
| legacy_i | input | 1 | Selects the legacy enable condition |
| leg_cif_i | input | 1 | Legacy control flag |
| leg_eif_i | input | 1 | Legacy interrupt flag |
| ack_i | input | 1 | Accepts the interrupt being delivered |
| eoi_i | input | 1 | Retires the highest in-service vector |
| deliver_o | output | 1 | An interrupt qualifies for delivery |
| fw_o | output | 1 | 1: firmware target, 0: external handler |
| fw_init_o | output | 1 | When fw_o = 1: 1 for init, 0 for performance monitor |
| vec_o | output | VEC_W | Delivered external vector (0 when fw_o = 1) |
| hp_vec_o | output | VEC_W | Highest unmasked pending vector, or 15 |

## Verification
The in-service mask is the hardest state to reach. The bench can only fill the in-service bitmap by acknowledging deliveries, and it can only read that bitmap back through its masking effect on later requests. The stimulus builds nested in-service stacks: vector 0 under vector 2, and vector 144 under vector 145. It then retires one entry at a time and re-raises a vector whose delivery depends on exactly which entry was cleared. This shows that end-of-interrupt removed the top entry and left the one below it. A firmware acknowledge is followed by a check that the non-maskable vector is still pending and still deliverable.

// File: rtl/intr_select_pkg.sv
package intr_select_pkg;

  localparam int NMI_VEC    = 2;
  localparam int EXTINT_VEC = 0;
  localparam int SPUR_VEC   = 15;
  localparam int FIRST_EXT  = 16;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_PMI  = 2'd2,
    SRC_INIT = 2'd3
  } src_e;

endpackage

// File: rtl/intr_hi_find.sv
// Index of the highest set bit.
module intr_hi_find #(
  parameter  int W  = 258,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/intr_state.sv
// Pending and in-service bitmaps; set dominates clear.
module intr_state #(
  parameter int NUM_VEC = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_pend_i,
  input  logic [NUM_VEC-1:0] clr_pend_i,
  input  logic [NUM_VEC-1:0] set_isr_i,
  input  logic [NUM_VEC-1:0] clr_isr_i,
  output logic [NUM_VEC-1:0] pend_q_o,
  output logic [NUM_VEC-1:0] isr_q_o
);

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q_o[g] <= 1'b0;
        isr_q_o[g]  <= 1'b0;
      end else begin
        pend_q_o[g] <= (pend_q_o[g] & ~clr_pend_i[g]) | set_pend_i[g];
        isr_q_o[g]  <= (isr_q_o[g] & ~clr_isr_i[g]) | set_isr_i[g];
      end
    end
  end

endmodule

// File: rtl/intr_qualify.sv
// Masking, enabling and source arbitration.
module intr_qualify
  import intr_select_pkg::*;
#(
  parameter  int NUM_VEC = 256,
  parameter  int CLASS_W = 4,
  localparam int VEC_W   = $clog2(NUM_VEC),
  localparam int RANK_W  = $clog2(NUM_VEC + 2)
) (
  input  logic               run_i,
  input  logic               pend_any_i,
  input  logic [RANK_W-1:0]  pend_rank_i,
  input  logic               isr_any_i,
  input  logic [RANK_W-1:0]  isr_rank_i,
  input  logic               init_req_i,
  input  logic               mchk_i,
  input  logic               pmi_req_i,
  input  logic               coll_en_i,
  input  logic               ien_i,
  input  logic               legacy_i,
  input  logic               leg_cif_i,
  input  logic               leg_eif_i,
  input  logic               mask_all_i,
  input  logic [CLASS_W-1:0] class_thr_i,
  output src_e               src_o,
  output logic [VEC_W-1:0]   sel_vec_o,
  output logic [VEC_W-1:0]   hp_vec_o,
  output logic [VEC_W-1:0]   isr_vec_o
);

  localparam logic [RANK_W-1:0] RANK_NMI  = RANK_W'(NUM_VEC + 1);
  localparam logic [RANK_W-1:0] RANK_XINT = RANK_W'(NUM_VEC);

  function automatic logic [VEC_W-1:0] rank2vec(input logic [RANK_W-1:0] r);
    if (r == RANK_NMI)       return VEC_W'(NMI_VEC);
    else if (r == RANK_XINT) return VEC_W'(EXTINT_VEC);
    else                     return r[VEC_W-1:0];
  endfunction

  logic [VEC_W-1:0]   pend_vec;
  logic [CLASS_W-1:0] pend_cls;
  logic               is_nmi, is_xint, above_isr, class_ok, unmasked;
  logic               ext_en, init_ok, pmi_ok, ext_ok;

  assign pend_vec  = rank2vec(pend_rank_i);
  assign isr_vec_o = rank2vec(isr_rank_i);
  assign pend_cls  = pend_vec[VEC_W-1 -: CLASS_W];
  assign is_nmi    = pend_rank_i == RANK_NMI;
  assign is_xint   = pend_rank_i == RANK_XINT;
  assign above_isr = !isr_any_i || (pend_rank_i > isr_rank_i);
  assign class_ok  = is_xint || (pend_cls > class_thr_i);

  // masking is monotone in rank, so only the top pending entry matters
  assign unmasked  = pend_any_i && above_isr && (is_nmi || (!mask_all_i && class_ok));
  assign hp_vec_o  = unmasked ? pend_vec : VEC_W'(SPUR_VEC);

  assign ext_en  = ien_i && (!legacy_i || !leg_cif_i || leg_eif_i);
  assign init_ok = init_req_i && !mchk_i;
  assign pmi_ok  = pmi_req_i && coll_en_i;
  assign ext_ok  = ext_en && unmasked;

  always_comb begin
    src_o = SRC_NONE;
    if (run_i) begin
      if (init_ok)     src_o = SRC_INIT;
      else if (pmi_ok) src_o = SRC_PMI;
      else if (ext_ok) src_o = SRC_EXT;
    end
  end

  assign sel_vec_o = (src_o == SRC_EXT) ? pend_vec : '0;

endmodule

// File: rtl/intr_select.sv
module intr_select
  import intr_select_pkg::*;
#(
  parameter  int NUM_VEC = 256,
  parameter  int CLASS_W = 4,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] raise_i,
  input  logic               init_req_i,
  input  logic               pmi_req_i,
  input  logic               mask_all_i,
  input  logic [CLASS_W-1:0] class_thr_i,
  input  logic               mchk_i,
  input  logic               coll_en_i,
  input  logic               ien_i,
  input  logic               legacy_i,
  input  logic               leg_cif_i,
  input  logic               leg_eif_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               deliver_o,
  output logic               fw_o,
  output logic               fw_init_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [VEC_W-1:0]   hp_vec_o
);

  localparam int RANK_N = NUM_VEC + 2;
  localparam int RANK_W = $clog2(RANK_N);

  logic               run_q;
  logic [NUM_VEC-1:0] pend_q, isr_q;
  logic [NUM_VEC-1:0] set_pend, clr_pend, set_isr, clr_isr;
  logic [RANK_N-1:0]  pend_rk, isr_rk;
  logic               pend_any, isr_any, ack_en, eoi_en;
  logic [RANK_W-1:0]  pend_idx, isr_idx;
  logic [VEC_W-1:0]   sel_vec, isr_vec;
  src_e               src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  // rank order: NMI on top, ExtINT next, then vector number.
  // Low 16 slots repeat vectors 0/2 but can never win over their top copies.
  assign pend_rk = {pend_q[NMI_VEC], pend_q[EXTINT_VEC], pend_q};
  assign isr_rk  = {isr_q[NMI_VEC], isr_q[EXTINT_VEC], isr_q};

  intr_hi_find #(.W(RANK_N)) u_pend_find (
    .req_i(pend_rk), .any_o(pend_any), .idx_o(pend_idx)
  );

  intr_hi_find #(.W(RANK_N)) u_isr_find (
    .req_i(isr_rk), .any_o(isr_any), .idx_o(isr_idx)
  );

  intr_qualify #(.NUM_VEC(NUM_VEC), .CLASS_W(CLASS_W)) u_qual (
    .run_i      (run_q),
    .pend_any_i (pend_any),
    .pend_rank_i(pend_idx),
    .isr_any_i  (isr_any),
    .isr_rank_i (isr_idx),
    .init_req_i (init_req_i),
    .mchk_i     (mchk_i),
    .pmi_req_i  (pmi_req_i),
    .coll_en_i  (coll_en_i),
    .ien_i      (ien_i),
    .legacy_i   (legacy_i),
    .leg_cif_i  (leg_cif_i),
    .leg_eif_i  (leg_eif_i),
    .mask_all_i (mask_all_i),
    .class_thr_i(class_thr_i),
    .src_o      (src),
    .sel_vec_o  (sel_vec),
    .hp_vec_o   (hp_vec_o),
    .isr_vec_o  (isr_vec)
  );

  assign ack_en = ack_i && (src == SRC_EXT);
  assign eoi_en = eoi_i && isr_any;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ctl
    localparam logic [VEC_W-1:0] GV = VEC_W'(g);
    localparam bit LEGAL = (g == EXTINT_VEC) || (g == NMI_VEC) || (g >= FIRST_EXT);
    assign set_pend[g] = raise_i[g] & LEGAL;
    assign clr_pend[g] = ack_en && (sel_vec == GV);
    assign set_isr[g]  = ack_en && (sel_vec == GV);
    assign clr_isr[g]  = eoi_en && (isr_vec == GV);
  end

  intr_state #(.NUM_VEC(NUM_VEC)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_pend_i(set_pend),
    .clr_pend_i(clr_pend),
    .set_isr_i (set_isr),
    .clr_isr_i (clr_isr),
    .pend_q_o  (pend_q),
    .isr_q_o   (isr_q)
  );

  assign deliver_o = src != SRC_NONE;
  assign fw_o      = (src == SRC_PMI) || (src == SRC_INIT);
  assign fw_init_o = src == SRC_INIT;
  assign vec_o     = sel_vec;

endmodule

// File: rtl/intr_select_chk.sv
module intr_select_chk #(
  parameter  int NUM_VEC = 256,
  parameter  int CLASS_W = 4,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               init_req_i,
  input logic               mchk_i,
  input logic               pmi_req_i,
  input logic               coll_en_i,
  input logic               ien_i,
  input logic               legacy_i,
  input logic               leg_cif_i,
  input logic               leg_eif_i,
  input logic               mask_all_i,
  input logic [CLASS_W-1:0] class_thr_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               deliver_o,
  input logic               fw_o,
  input logic               fw_init_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [VEC_W-1:0]   hp_vec_o,
  input logic [NUM_VEC-1:0] isr_q
);

  p_init_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o && init_req_i && !mchk_i) |-> (fw_o && fw_init_o));

  p_pmi_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o && fw_o && !fw_init_o) |-> (pmi_req_i && coll_en_i));

  p_ext_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o && !fw_o) |-> (ien_i && (!legacy_i || !leg_cif_i || leg_eif_i)));

  p_class_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o && !fw_o && vec_o >= VEC_W'(16))
      |-> (!mask_all_i && (vec_o[VEC_W-1 -: CLASS_W] > class_thr_i)));

  p_hp_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o && !fw_o) |-> (hp_vec_o == vec_o));

  p_ack_isr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && deliver_o && !fw_o) |=> isr_q[$past(vec_o)]);

  p_eoi_one_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(ack_i && deliver_o && !fw_o) && (isr_q != '0))
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  p_fw_ack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && deliver_o && fw_o && !eoi_i) |=> $stable(isr_q));

endmodule

bind intr_select intr_select_chk #(.NUM_VEC(NUM_VEC), .CLASS_W(CLASS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_req_i (init_req_i),
  .mchk_i     (mchk_i),
  .pmi_req_i  (pmi_req_i),
  .coll_en_i  (coll_en_i),
  .ien_i      (ien_i),
  .legacy_i   (legacy_i),
  .leg_cif_i  (leg_cif_i),
  .leg_eif_i  (leg_eif_i),
  .mask_all_i (mask_all_i),
  .class_thr_i(class_thr_i),
  .ack_i      (ack_i),
  .eoi_i      (eoi_i),
  .deliver_o  (deliver_o),
  .fw_o       (fw_o),
  .fw_init_o  (fw_init_o),
  .vec_o      (vec_o),
  .hp_vec_o   (hp_vec_o),
  .isr_q      (isr_q)
);

// File: tb/intr_select_bench.sv
`timescale 1ns/1ps
module intr_select_bench;

  localparam int  NUM_VEC = 256;
  localparam int  CLASS_W = 4;
  localparam int  VEC_W   = 8;
  localparam time CLK_T   = 20ns;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [NUM_VEC-1:0] raise_i = '0;
  logic               init_req_i = 0, pmi_req_i = 0, mask_all_i = 0;
  logic [CLASS_W-1:0] class_thr_i = '0;
  logic               mchk_i = 0, coll_en_i = 0, ien_i = 1;
  logic               legacy_i = 0, leg_cif_i = 0, leg_eif_i = 0;
  logic               ack_i = 0, eoi_i = 0;
  logic               deliver_o, fw_o, fw_init_o;
  logic [VEC_W-1:0]   vec_o, hp_vec_o;

  always #(CLK_T/2) clk_i = ~clk_i;

  intr_select #(.NUM_VEC(NUM_VEC), .CLASS_W(CLASS_W)) u_intr_select (.*);

  typedef struct {
    bit       d;
    bit       fw;
    bit       ini;
    int       vec;
    int       hp;
    string    tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  // scoreboard monitor
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      n_chk++;
      if (deliver_o !== e.d || hp_vec_o !== VEC_W'(e.hp) ||
          (e.d && fw_o !== e.fw) ||
          (e.d && e.fw && fw_init_o !== e.ini) ||
          (e.d && !e.fw && vec_o !== VEC_W'(e.vec))) begin
        n_fail++;
        $display("FAIL %s: actual d=%0b fw=%0b ini=%0b vec=%0d hp=%0d expected d=%0b fw=%0b ini=%0b vec=%0d hp=%0d",
                 e.tag, deliver_o, fw_o, fw_init_o, vec_o, hp_vec_o,
                 e.d, e.fw, e.ini, e.vec, e.hp);
      end
    end
  end

  task automatic expect_out(bit d, bit fw, bit ini, int vec, int hp, string tag);
    exp_t e;
    #2;
    e.d = d; e.fw = fw; e.ini = ini; e.vec = vec; e.hp = hp; e.tag = tag;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic raise(int v);
    @(negedge clk_i);
    raise_i = '0;
    raise_i[v] = 1'b1;
    @(negedge clk_i);
    raise_i = '0;
  endtask

  task automatic do_ack();
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    @(negedge clk_i);
    eoi_i = 1'b1;
    @(negedge clk_i);
    eoi_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_T * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    init_req_i = 1'b1;
    repeat (2) @(negedge clk_i);
    expect_out(0, 0, 0, 0, 15, "R1 in reset");
    rst_ni = 1'b1;
    expect_out(0, 0, 0, 0, 15, "R1 first cycle");
    @(negedge clk_i);
    init_req_i = 1'b0;
    expect_out(0, 0, 0, 0, 15, "R1 idle after reset");

    raise(1); raise(3); raise(15);
    expect_out(0, 0, 0, 0, 15, "R2 illegal vectors ignored");
    raise(32);
    expect_out(1, 0, 0, 32, 32, "R2 vector 32 pending");
    raise(47);
    expect_out(1, 0, 0, 47, 47, "R3 same class higher wins");
    raise(144);
    expect_out(1, 0, 0, 144, 144, "R3 higher class");
    raise(0);
    expect_out(1, 0, 0, 0, 0, "R3 ExtINT above 255..16");
    raise(2);
    expect_out(1, 0, 0, 2, 2, "R3 NMI on top");

    @(negedge clk_i); ien_i = 0;
    expect_out(0, 0, 0, 0, 2, "R6 R9 disabled keeps hp");
    @(negedge clk_i); ien_i = 1; legacy_i = 1; leg_cif_i = 1; leg_eif_i = 0;
    expect_out(0, 0, 0, 0, 2, "R6 legacy blocked");
    @(negedge clk_i); leg_eif_i = 1;
    expect_out(1, 0, 0, 2, 2, "R6 legacy eflag");
    @(negedge clk_i); leg_cif_i = 0; leg_eif_i = 0;
    expect_out(1, 0, 0, 2, 2, "R6 legacy cflag clear");
    @(negedge clk_i); legacy_i = 0;

    @(negedge clk_i); pmi_req_i = 1;
    expect_out(1, 0, 0, 2, 2, "R5 pmi without collection");
    @(negedge clk_i); coll_en_i = 1;
    expect_out(1, 1, 0, 0, 2, "R5 pmi over external");
    @(negedge clk_i); init_req_i = 1;
    expect_out(1, 1, 1, 0, 2, "R4 init over pmi");
    @(negedge clk_i); mchk_i = 1;
    expect_out(1, 1, 0, 0, 2, "R4 init blocked by mchk");
    do_ack();
    init_req_i = 0; pmi_req_i = 0; mchk_i = 0; coll_en_i = 0;
    expect_out(1, 0, 0, 2, 2, "R12 firmware ack keeps maps");

    do_ack();
    expect_out(0, 0, 0, 0, 15, "R8 R10 NMI in service masks rest");
    do_eoi();
    expect_out(1, 0, 0, 0, 0, "R10 R11 NMI retired, ExtINT next");

    @(negedge clk_i); mask_all_i = 1;
    expect_out(0, 0, 0, 0, 15, "R7 mask-all blocks ExtINT");
    raise(2);
    expect_out(1, 0, 0, 2, 2, "R7 mask-all spares NMI");
    do_ack();
    do_eoi();
    mask_all_i = 0;
    expect_out(1, 0, 0, 0, 0, "R7 mask-all released");

    do_ack();
    expect_out(0, 0, 0, 0, 15, "R8 ExtINT in service masks 144");
    raise(2);
    expect_out(1, 0, 0, 2, 2, "R8 NMI above ExtINT in service");
    do_ack();
    expect_out(0, 0, 0, 0, 15, "R8 two in service");
    do_eoi();
    expect_out(0, 0, 0, 0, 15, "R11 only NMI retired");
    do_eoi();
    expect_out(1, 0, 0, 144, 144, "R11 ExtINT retired");

    @(negedge clk_i); class_thr_i = 4'd9;
    expect_out(0, 0, 0, 0, 15, "R7 class equal to threshold masked");
    @(negedge clk_i); class_thr_i = 4'd8;
    expect_out(1, 0, 0, 144, 144, "R7 class above threshold");
    @(negedge clk_i); class_thr_i = 4'd0;

    do_ack();
    expect_out(0, 0, 0, 0, 15, "R8 R10 144 in service");
    raise(145);
    expect_out(1, 0, 0, 145, 145, "R8 145 outranks 144");
    do_ack();
    expect_out(0, 0, 0, 0, 15, "R10 145 in service");
    do_eoi();
    raise(145);
    expect_out(1, 0, 0, 145, 145, "R11 eoi removed 145 not 144");
    do_ack();
    do_eoi();
    expect_out(0, 0, 0, 0, 15, "R11 144 still in service");
    do_eoi();
    expect_out(1, 0, 0, 47, 47, "R10 R3 masked requests kept");

    wait (exp_q.size() == 0);
    #5;
    done = 1;
    summary();
    $finish;
  end

endmodule